// File: doc/BRIEF.md
# Transmit Buffer Space Admission Gate

This block sits between an application and a set of per-session transmit buffers. Before sending any payload, the application asks for room: it gives a session number and a byte count. The block reads that session's free-space entry and answers. An accept reserves the space at once and reports how much is left. A reject carries a reason code. The requester can simply ask again later, once acknowledged data has freed space.

After an accept with a non-zero length, the block opens a pass-through path for exactly one packet on the payload AXI4-Stream. The packet goes toward the session buffer, tagged with the session number. The block counts the enabled bytes in that packet and flags a mismatch against the granted length. Acknowledged bytes come back through a credit port, and that space is added to the session's entry. A small control port opens a session, which gives it a full buffer, or closes it. Segmentation, retransmission and the buffer memory itself live elsewhere.

Top module: `tx_credit_gate`

## Requirements
- R1: A response echoes the request's 16-bit session number and 16-bit length. It holds every field stable while `rspValid` is high and `rspReady` is low.
- R2: A request to an open session is accepted (error code 0) when its length is at most the session's free space. The length is deducted in the cycle the request is taken. `rspSpace` reports the free space after the deduction, and an exact fit is accepted.
- R3: A request longer than the free space is rejected with error code 1. `rspSpace` reports the unchanged free space, and nothing is deducted.
- R4: A request to a closed session, or to a session number at or above `NUM_SESSIONS`, is rejected with error code 2 and `rspSpace` of 0. Error code 3 is never produced.
- R5: Payload is admitted (`inReady` high) only between the acceptance of a non-zero-length request and the last beat of its packet. After a reject, or after a zero-length accept, offered beats are not taken and `bufValid` stays low.
- R6: While a packet is being admitted, no new request is taken (`reqReady` low).
- R7: When the last beat is taken, the block adds up the keep bits of all beats in the packet (one keep bit per data byte). If the sum differs from the granted length, `lenErr` pulses high for exactly one cycle, in the cycle after that beat. If the sum matches, `lenErr` stays low.
- R8: A credit for an open session adds its byte count to the free space. The result saturates at `BUF_BYTES`.
- R9: Opening a session sets its free space to `BUF_BYTES`. Closing a session makes later requests to it fail with error code 2.
- R10: After reset, `reqReady` is 1, `rspValid`, `inReady` and `lenErr` are 0, and every session is closed.
- R11: Admitted beats pass through unchanged on `bufData`, `bufKeep` and `bufLast`, with `bufSid` set to the granted session. Back-pressure on `bufReady` stalls `inReady` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Space request valid |
| reqReady | output | 1 | Space request taken |
| reqSid | input | 16 | Requested session |
| reqLen | input | 16 | Requested byte count |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Response consumed |
| rspSid | output | 16 | Echoed session |
| rspLen | output | 16 | Echoed byte count |
| rspSpace | output | 30 | Free space reported with the answer |
| rspErr | output | 2 | 0 accepted, 1 short of space, 2 session not open |
| inValid | input | 1 | Payload beat valid |
| inReady | output | 1 | Payload beat taken |
| inData | input | DATA_BYTES*8 | Payload data |
| inKeep | input | DATA_BYTES | Byte enables |
| inLast | input | 1 | Final beat of packet |
| bufValid | output | 1 | Beat toward buffer valid |
| bufReady | input | 1 | Buffer can take a beat |
| bufData | output | DATA_BYTES*8 | Forwarded data |
| bufKeep | output | DATA_BYTES | Forwarded byte enables |
| bufLast | output | 1 | Forwarded final flag |
| bufSid | output | 16 | Session the beat belongs to |
| credValid | input | 1 | Space return valid |
| credSid | input | 16 | Session receiving space back |
| credBytes | input | 16 | Bytes returned |
| ctlValid | input | 1 | Session open/close command |
| ctlSid | input | 16 | Session affected |
| ctlOpen | input | 1 | 1 opens with a full buffer, 0 closes |
| lenErr | output | 1 | One-cycle pulse when the packet size differs from the grant |

## Verification
The properties assume three things about the application. It holds a presented request until the block takes it. It keeps `rspReady` and the payload handshake compliant with AXI4-Stream. It never sends an open or close command for a session whose request is being taken in the same cycle. The directed stimulus follows these rules. Requests, credits and control commands are driven only on falling edges, one at a time. Payload is offered only after a response has been consumed. Each command is a single-cycle pulse issued while the gate is idle.

// File: rtl/txgate_pkg.sv
package txgate_pkg;
  typedef enum logic [1:0] {
    ERR_OK      = 2'd0,
    ERR_NOSPACE = 2'd1,
    ERR_CLOSED  = 2'd2,
    ERR_RSVD    = 2'd3
  } gateErr_e;

  // Strobes from the control FSM to the space datapath
  typedef struct packed {
    logic reqTake;   // request handshake this cycle
    logic beatTake;  // payload beat handshake this cycle
    logic lastTake;  // final payload beat handshake this cycle
  } gateStrobe_t;
endpackage

// File: rtl/txgate_ctrl.sv
module txgate_ctrl
  import txgate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        rspReady,
  input  logic        inValid,
  input  logic        inLast,
  input  logic        bufReady,
  input  logic        dataPending,
  output logic        reqReady,
  output logic        rspValid,
  output logic        passOpen,
  output gateStrobe_t strobe
);
  typedef enum logic [1:0] {S_IDLE, S_RESP, S_DATA} state_e;
  state_e state, stateNext;

  always_comb begin
    reqReady        = (state == S_IDLE);
    rspValid        = (state == S_RESP);
    passOpen        = (state == S_DATA);
    strobe.reqTake  = reqReady && reqValid;
    strobe.beatTake = passOpen && inValid && bufReady;
    strobe.lastTake = strobe.beatTake && inLast;
    stateNext       = state;
    case (state)
      S_IDLE: if (strobe.reqTake) stateNext = S_RESP;
      S_RESP: if (rspReady) stateNext = dataPending ? S_DATA : S_IDLE;
      S_DATA: if (strobe.lastTake) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/txgate_space_dp.sv
module txgate_space_dp
  import txgate_pkg::*;
#(
  parameter int DATA_BYTES   = 64,
  parameter int NUM_SESSIONS = 16,
  parameter int BUF_BYTES    = 65536
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  gateStrobe_t           strobe,
  input  logic [15:0]           reqSid,
  input  logic [15:0]           reqLen,
  input  logic                  credValid,
  input  logic [15:0]           credSid,
  input  logic [15:0]           credBytes,
  input  logic                  ctlValid,
  input  logic [15:0]           ctlSid,
  input  logic                  ctlOpen,
  input  logic [DATA_BYTES-1:0] inKeep,
  output logic [15:0]           rspSid,
  output logic [15:0]           rspLen,
  output logic [29:0]           rspSpace,
  output logic [1:0]            rspErr,
  output logic                  dataPending,
  output logic                  lenErr
);
  localparam int IDX_W   = $clog2(NUM_SESSIONS);
  localparam int SPACE_W = 30;
  localparam int KCNT_W  = $clog2(DATA_BYTES + 1);
  localparam int CNT_W   = 24;
  localparam logic [SPACE_W-1:0] FULL = SPACE_W'(BUF_BYTES);

  logic [SPACE_W-1:0]      freeArr [NUM_SESSIONS];
  logic [NUM_SESSIONS-1:0] openVec;

  // Request lookup and decision
  logic               reqInRange, curOpen, fits;
  logic [IDX_W-1:0]   reqIdx;
  logic [SPACE_W-1:0] curFree;
  gateErr_e           reqErr;

  always_comb begin
    reqInRange = ({16'b0, reqSid} < 32'(NUM_SESSIONS));
    reqIdx     = reqSid[IDX_W-1:0];
    curOpen    = reqInRange && openVec[reqIdx];
    curFree    = reqInRange ? freeArr[reqIdx] : '0;
    fits       = ({14'b0, reqLen} <= curFree);
    if (!curOpen)   reqErr = ERR_CLOSED;
    else if (!fits) reqErr = ERR_NOSPACE;
    else            reqErr = ERR_OK;
  end

  // Per-session free-space entries
  for (genvar g = 0; g < NUM_SESSIONS; g++) begin : g_sess
    logic               openQ, ctlHit, deduct, credit;
    logic [SPACE_W-1:0] spaceQ;
    logic [SPACE_W:0]   sum;

    assign ctlHit = ctlValid && (ctlSid == 16'(g));
    assign deduct = strobe.reqTake && reqInRange && (reqIdx == IDX_W'(g)) && (reqErr == ERR_OK);
    assign credit = credValid && (credSid == 16'(g)) && openQ;

    always_comb begin
      sum = {1'b0, spaceQ};
      if (deduct) sum = sum - {15'b0, reqLen};
      if (credit) sum = sum + {15'b0, credBytes};
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        openQ  <= 1'b0;
        spaceQ <= '0;
      end else if (ctlHit) begin
        openQ  <= ctlOpen;
        spaceQ <= ctlOpen ? FULL : '0;
      end else if (sum > {1'b0, FULL}) begin
        spaceQ <= FULL;
      end else begin
        spaceQ <= sum[SPACE_W-1:0];
      end
    end

    assign freeArr[g] = spaceQ;
    assign openVec[g] = openQ;
  end

  // Keep-bit population count for the current beat
  logic [KCNT_W-1:0] keepCount;
  always_comb begin
    keepCount = '0;
    for (int b = 0; b < DATA_BYTES; b++) keepCount = keepCount + KCNT_W'(inKeep[b]);
  end

  logic [CNT_W-1:0] byteCnt, byteSum;
  assign byteSum = byteCnt + CNT_W'(keepCount);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspSid      <= '0;
      rspLen      <= '0;
      rspSpace    <= '0;
      rspErr      <= ERR_OK;
      dataPending <= 1'b0;
      byteCnt     <= '0;
      lenErr      <= 1'b0;
    end else begin
      lenErr <= strobe.lastTake && (byteSum != CNT_W'(rspLen));
      if (strobe.reqTake) begin
        rspSid      <= reqSid;
        rspLen      <= reqLen;
        rspErr      <= reqErr;
        dataPending <= (reqErr == ERR_OK) && (reqLen != 16'd0);
        byteCnt     <= '0;
        case (reqErr)
          ERR_OK:      rspSpace <= curFree - {14'b0, reqLen};
          ERR_NOSPACE: rspSpace <= curFree;
          default:     rspSpace <= '0;
        endcase
      end else if (strobe.beatTake) begin
        byteCnt <= byteSum;
      end
    end
  end
endmodule

// File: rtl/tx_credit_gate.sv
module tx_credit_gate
  import txgate_pkg::*;
#(
  parameter int DATA_BYTES   = 64,
  parameter int NUM_SESSIONS = 16,
  parameter int BUF_BYTES    = 65536
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [15:0]             reqSid,
  input  logic [15:0]             reqLen,
  output logic                    rspValid,
  input  logic                    rspReady,
  output logic [15:0]             rspSid,
  output logic [15:0]             rspLen,
  output logic [29:0]             rspSpace,
  output logic [1:0]              rspErr,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [DATA_BYTES*8-1:0] inData,
  input  logic [DATA_BYTES-1:0]   inKeep,
  input  logic                    inLast,
  output logic                    bufValid,
  input  logic                    bufReady,
  output logic [DATA_BYTES*8-1:0] bufData,
  output logic [DATA_BYTES-1:0]   bufKeep,
  output logic                    bufLast,
  output logic [15:0]             bufSid,
  input  logic                    credValid,
  input  logic [15:0]             credSid,
  input  logic [15:0]             credBytes,
  input  logic                    ctlValid,
  input  logic [15:0]             ctlSid,
  input  logic                    ctlOpen,
  output logic                    lenErr
);
  gateStrobe_t strobe;
  logic        passOpen, dataPending;

  txgate_ctrl ctrl_i (
    .clk, .rstN, .reqValid, .rspReady, .inValid, .inLast, .bufReady,
    .dataPending, .reqReady, .rspValid, .passOpen, .strobe
  );

  txgate_space_dp #(
    .DATA_BYTES(DATA_BYTES), .NUM_SESSIONS(NUM_SESSIONS), .BUF_BYTES(BUF_BYTES)
  ) dp_i (
    .clk, .rstN, .strobe, .reqSid, .reqLen, .credValid, .credSid, .credBytes,
    .ctlValid, .ctlSid, .ctlOpen, .inKeep, .rspSid, .rspLen, .rspSpace,
    .rspErr, .dataPending, .lenErr
  );

  assign inReady  = passOpen && bufReady;
  assign bufValid = passOpen && inValid;
  assign bufData  = inData;
  assign bufKeep  = inKeep;
  assign bufLast  = inLast;
  assign bufSid   = rspSid;
endmodule

// File: rtl/tx_credit_gate_chk.sv
module tx_credit_gate_chk #(
  parameter int BUF_BYTES = 65536
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqReady,
  input logic        rspValid,
  input logic        rspReady,
  input logic [15:0] rspSid,
  input logic [15:0] rspLen,
  input logic [29:0] rspSpace,
  input logic [1:0]  rspErr,
  input logic        inValid,
  input logic        inReady,
  input logic        inLast,
  input logic        bufValid,
  input logic        lenErr
);
  p_rsp_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspSid) && $stable(rspLen)
                              && $stable(rspErr) && $stable(rspSpace));

  p_no_rsvd_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> rspErr != 2'd3);

  p_short_space_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspErr == 2'd1 |-> rspSpace < {14'b0, rspLen});

  p_closed_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspErr == 2'd2 |-> rspSpace == 30'd0);

  p_space_cap_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> rspSpace <= 30'(BUF_BYTES));

  p_reject_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspReady && rspErr != 2'd0 |=> !inReady);

  p_no_req_in_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    bufValid |-> !reqReady && !rspValid);

  p_lenerr_after_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    lenErr |-> $past(inValid && inReady && inLast));
endmodule

bind tx_credit_gate tx_credit_gate_chk #(.BUF_BYTES(BUF_BYTES)) chk_i (
  .clk, .rstN, .reqReady, .rspValid, .rspReady, .rspSid, .rspLen, .rspSpace,
  .rspErr, .inValid, .inReady, .inLast, .bufValid, .lenErr
);

// File: tb/tx_credit_gate_tb_top.sv
module tx_credit_gate_tb_top;
  localparam int DB  = 8;
  localparam int NS  = 4;
  localparam int BUF = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic          reqValid = 0, rspReady = 0, inValid = 0, inLast = 0, bufReady = 1;
  logic          credValid = 0, ctlValid = 0, ctlOpen = 0;
  logic [15:0]   reqSid = 0, reqLen = 0, credSid = 0, credBytes = 0, ctlSid = 0;
  logic [DB*8-1:0] inData = '0;
  logic [DB-1:0] inKeep = '0;
  logic          reqReady, rspValid, inReady, bufValid, bufLast, lenErr;
  logic [15:0]   rspSid, rspLen, bufSid;
  logic [29:0]   rspSpace;
  logic [1:0]    rspErr;
  logic [DB*8-1:0] bufData;
  logic [DB-1:0] bufKeep;

  int nChk = 0, nBad = 0;
  bit done = 0;

  tx_credit_gate #(.DATA_BYTES(DB), .NUM_SESSIONS(NS), .BUF_BYTES(BUF)) dut_i (
    .clk, .rstN, .reqValid, .reqReady, .reqSid, .reqLen, .rspValid, .rspReady,
    .rspSid, .rspLen, .rspSpace, .rspErr, .inValid, .inReady, .inData, .inKeep,
    .inLast, .bufValid, .bufReady, .bufData, .bufKeep, .bufLast, .bufSid,
    .credValid, .credSid, .credBytes, .ctlValid, .ctlSid, .ctlOpen, .lenErr
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ctlCmd(input int sid, input bit open);
    @(negedge clk); ctlValid = 1; ctlSid = 16'(sid); ctlOpen = open;
    @(negedge clk); ctlValid = 0;
  endtask

  task automatic credit(input int sid, input int bytes);
    @(negedge clk); credValid = 1; credSid = 16'(sid); credBytes = 16'(bytes);
    @(negedge clk); credValid = 0;
  endtask

  // Issue one request, hold the response one cycle, then consume it
  task automatic request(input int sid, input int len, input int expErr, input int expSpace, input string tag);
    @(negedge clk);
    chk(reqReady == 1, {tag, " reqReady idle"}, reqReady, 1);
    reqValid = 1; reqSid = 16'(sid); reqLen = 16'(len);
    @(negedge clk); reqValid = 0;
    chk(rspValid == 1, {tag, " R1 rspValid"}, rspValid, 1);
    chk(rspSid == 16'(sid) && rspLen == 16'(len), {tag, " R1 echo"}, rspLen, len);
    chk(rspErr == 2'(expErr), {tag, " err"}, rspErr, expErr);
    chk(rspSpace == 30'(expSpace), {tag, " space"}, rspSpace, expSpace);
    @(negedge clk);
    chk(rspValid == 1 && rspSpace == 30'(expSpace) && rspErr == 2'(expErr), {tag, " R1 hold"}, rspSpace, expSpace);
    rspReady = 1;
    @(negedge clk); rspReady = 0;
  endtask

  // Send nBytes of payload, stalling the first beat once; check forwarding and lenErr
  task automatic payload(input int sid, input int nBytes, input bit expLenErr, input string tag);
    int beats = (nBytes + DB - 1) / DB;
    for (int i = 0; i < beats; i++) begin
      int rem = nBytes - i * DB;
      bit fire;
      inValid = 1;
      inData  = {DB{8'(i + 8'h30)}};
      inKeep  = (rem >= DB) ? '1 : DB'((1 << rem) - 1);
      inLast  = (i == beats - 1);
      if (i == 0) begin
        bufReady = 0;
        #0;
        @(posedge clk); @(negedge clk);
        chk(inReady == 0 && bufValid == 1, {tag, " R11 stall"}, inReady, 0);
        bufReady = 1;
      end
      do begin
        #0;
        chk(bufValid == 1 && bufData == inData && bufKeep == inKeep && bufLast == inLast
            && bufSid == 16'(sid), {tag, " R11 pass"}, bufData[7:0], inData[7:0]);
        chk(reqReady == 0, {tag, " R6 busy"}, reqReady, 0);
        fire = inReady;
        @(posedge clk); @(negedge clk);
      end while (!fire);
    end
    inValid = 0; inLast = 0;
    chk(lenErr == expLenErr, {tag, " R7 lenErr"}, lenErr, expLenErr);
    @(negedge clk);
    chk(lenErr == 0, {tag, " R7 pulse ends"}, lenErr, 0);
  endtask

  task automatic noAdmit(input string tag);
    @(negedge clk); inValid = 1; inKeep = '1; inLast = 1;
    #0;
    chk(inReady == 0 && bufValid == 0, {tag, " R5 blocked"}, inReady, 0);
    @(negedge clk);
    chk(inReady == 0 && bufValid == 0, {tag, " R5 still blocked"}, bufValid, 0);
    inValid = 0; inLast = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(reqReady == 1 && rspValid == 0, "R10 handshake idle", rspValid, 0);
    chk(inReady == 0 && lenErr == 0, "R10 payload idle", inReady, 0);
    request(0, 4, 2, 0, "R10 closed after reset");
  endtask

  task automatic t_closed();
    request(9, 8, 2, 0, "R4 out of range");
    request(3, 1, 2, 0, "R4 never opened");
  endtask

  task automatic t_accept();
    ctlCmd(0, 1);
    request(0, 20, 0, 44, "R2 accept");
    payload(0, 20, 0, "R2 packet");
  endtask

  task automatic t_short();
    request(0, 50, 1, 44, "R3 short");
    noAdmit("R3 after reject");
    request(0, 44, 0, 0, "R2 exact fit");
    payload(0, 40, 1, "R7 mismatch");
  endtask

  task automatic t_credit();
    credit(0, 30);
    request(0, 64, 1, 30, "R8 partial credit");
    credit(0, 100);
    request(0, 64, 0, 0, "R8 saturated");
    payload(0, 64, 0, "R8 full packet");
  endtask

  task automatic t_zero();
    ctlCmd(1, 1);
    request(1, 0, 0, 64, "R9 open full zero len");
    noAdmit("R5 zero length");
  endtask

  task automatic t_close();
    ctlCmd(0, 0);
    request(0, 1, 2, 0, "R9 closed");
    ctlCmd(0, 1);
    request(0, 64, 0, 0, "R9 reopened");
    payload(0, 64, 0, "R9 packet");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_closed();
    t_accept();
    t_short();
    t_credit();
    t_zero();
    t_close();
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule